// File: doc/BRIEF.md
# Split-Halfword GPIO Controller with Edge Interrupts

This block is a 32-pin general-purpose I/O controller. Software reaches it through a 16-bit register port. Every 32-bit state register (output, input, falling-edge enable, rising-edge enable, interrupt status) is split into a low and a high 16-bit half. The two halves sit in two register banks that are 0x500 apart. A write changes only the half it addresses.

The input pins pass through a two-flop synchroniser. A level change on a pin whose matching edge enable is set overwrites the status register with a one-hot mask of that pin and raises the interrupt line. The status does not accumulate, so only the most recent edge is kept. If several pins qualify in the same cycle, the lowest-numbered pin is recorded. Reading the high status half clears the status and drops the interrupt.

A three-bit backlight level is decoded from a word built from output bits 18:16 and a separate three-bit enable field. Output bits 29 and 30 drive a two-wire serial data line and clock line.

Top module: `gpio_split_irq`

## Requirements
- R1: After reset, both input halves read 0xFFFF. The output, both enable registers, the status and the backlight enable field read 0. The interrupt, all outputs and the serial lines are 0, and the backlight level is 7.
- R2: The low halves are at output 0x00C, input 0x010, falling enable 0x014, rising enable 0x018 and status 0x020. The high halves are at the same offsets plus 0x500. A write to output or to an enable half changes only those 16 bits, and they read back unchanged.
- R3: The input halves read the pin levels two clock edges after the pins change.
- R4: A rising level on a pin whose rising enable bit is set loads the status with that pin's one-hot mask and raises the interrupt line.
- R5: A falling level on a pin whose falling enable bit is set does the same. An edge whose enable bit is clear leaves the status and the interrupt unchanged.
- R6: A new qualifying edge replaces the status contents; earlier bits are not kept.
- R7: When several pins qualify in the same cycle, only the lowest-numbered one is recorded.
- R8: A read of the high status half returns the status and then clears it and drops the interrupt. A read of the low status half does not clear it. Read data appears one cycle after the read strobe.
- R9: Offset 0x508 stores bits 2:0 of the write data as the backlight enable field and reads back only those bits.
- R10: The backlight word is output bits 18:16 at word bits 18:16 plus the enable field at word bits 2:0. It is re-decoded after any write to 0x508 or to the high output half. The decode is 0x00000007→0, 0x00020000→1, 0x00020001→2, 0x00040000→3, 0x00010006→4, 0x00020005→5, 0x00040003→6, and any other word→7.
- R11: Output bit 29 drives the serial data line and bit 30 drives the serial clock line. Both change only on a write to the high output half.
- R12: Writes to the input or status halves and to unmapped offsets are ignored. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after the strobe |
| pins_in | input | 32 | Asynchronous input pins |
| pins_out | output | 32 | Output register |
| bl_level | output | 3 | Decoded backlight level |
| ser_sda | output | 1 | Serial data line (output bit 29) |
| ser_scl | output | 1 | Serial clock line (output bit 30) |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check several properties on every cycle:
- the status stays one-hot or zero and agrees with the interrupt line;
- any qualifying edge raises the interrupt on the next cycle, and the recorded pin is the lowest qualifying one;
- a clearing read with no coincident edge empties the status;
- a low output write leaves the high half untouched;
- the serial lines and the backlight level hold between the writes that may change them.

Only the bench scenarios can show the rest:
- the exact register offsets and read data;
- the two-edge input latency;
- that an edge with a clear enable is ignored;
- that a later edge overwrites rather than accumulates;
- the full backlight table and the ignored writes.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_IN   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_FALL = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_RISE = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h020;
  localparam logic [ADDR_W-1:0] HI_STEP  = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_BLEN = 12'h508;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT_LO, SEL_OUT_HI, SEL_IN_LO, SEL_IN_HI,
    SEL_FALL_LO, SEL_FALL_HI, SEL_RISE_LO, SEL_RISE_HI,
    SEL_STAT_LO, SEL_STAT_HI, SEL_BLEN
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if      (a == OFS_OUT)            s = SEL_OUT_LO;
    else if (a == OFS_OUT + HI_STEP)  s = SEL_OUT_HI;
    else if (a == OFS_IN)             s = SEL_IN_LO;
    else if (a == OFS_IN + HI_STEP)   s = SEL_IN_HI;
    else if (a == OFS_FALL)           s = SEL_FALL_LO;
    else if (a == OFS_FALL + HI_STEP) s = SEL_FALL_HI;
    else if (a == OFS_RISE)           s = SEL_RISE_LO;
    else if (a == OFS_RISE + HI_STEP) s = SEL_RISE_HI;
    else if (a == OFS_STAT)           s = SEL_STAT_LO;
    else if (a == OFS_STAT + HI_STEP) s = SEL_STAT_HI;
    else if (a == OFS_BLEN)           s = SEL_BLEN;
    return s;
  endfunction

  function automatic logic [2:0] bl_decode(input logic [31:0] w);
    logic [2:0] lvl;
    case (w)
      32'h0000_0007: lvl = 3'd0;
      32'h0002_0000: lvl = 3'd1;
      32'h0002_0001: lvl = 3'd2;
      32'h0004_0000: lvl = 3'd3;
      32'h0001_0006: lvl = 3'd4;
      32'h0002_0005: lvl = 3'd5;
      32'h0004_0003: lvl = 3'd6;
      default:       lvl = 3'd7;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= pins_i;
      stab_q <= meta_q;
    end
  end

  assign level_o = stab_q;
  assign rise_o  = meta_q & ~stab_q;
  assign fall_o  = ~meta_q & stab_q;

endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic         clear_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] qual, pick, status_d, status_q;
  logic         hit, irq_d, irq_q;

  always_comb begin
    qual     = (rise_i & rise_en_i) | (fall_i & fall_en_i);
    pick     = qual & ((~qual) + ONE);
    hit      = |qual;
    status_d = status_q;
    irq_d    = irq_q;
    if (hit) begin
      status_d = pick;
      irq_d    = 1'b1;
    end else if (clear_i) begin
      status_d = '0;
      irq_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R6: status never holds more than one pin
  a_r6_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q));

  a_r8_irq_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|status_q));

  a_r4_edge_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|((rise_i & rise_en_i) | (fall_i & fall_en_i))) |=> irq_q);

  a_r7_lowest_pin: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (($past(qual) & (status_q - ONE)) == '0) && ((status_q & $past(qual)) != '0));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !hit) |=> (status_q == '0) && !irq_q);

endmodule

// File: rtl/gpio_bl_level.sv
module gpio_bl_level (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_i,
  input  logic [31:0] word_i,
  output logic [2:0]  level_o
);
  import gpio_split_pkg::*;

  logic [2:0] level_d, level_q;

  always_comb begin
    level_d = level_q;
    if (upd_i) level_d = bl_decode(word_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 3'd7;
    else        level_q <= level_d;
  end

  assign level_o = level_q;

  // R10: level only moves on a backlight-relevant write
  a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(level_q));

endmodule

// File: rtl/gpio_split_irq.sv
module gpio_split_irq #(
  parameter int HALF_W  = 16,
  parameter int BL_LSB  = 16,
  parameter int BLEN_W  = 3,
  parameter int SDA_BIT = 29,
  parameter int SCL_BIT = 30
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic                              reg_re,
  input  logic [gpio_split_pkg::ADDR_W-1:0] reg_addr,
  input  logic [HALF_W-1:0]                 reg_wdata,
  output logic [HALF_W-1:0]                 reg_rdata,
  input  logic [2*HALF_W-1:0]               pins_in,
  output logic [2*HALF_W-1:0]               pins_out,
  output logic [2:0]                        bl_level,
  output logic                              ser_sda,
  output logic                              ser_scl,
  output logic                              irq
);
  import gpio_split_pkg::*;

  localparam int NPIN = 2 * HALF_W;

  reg_sel_e           sel;
  logic [NPIN-1:0]    out_d, out_q, fall_d, fall_q, rise_d, rise_q;
  logic [BLEN_W-1:0]  blen_d, blen_q;
  logic [HALF_W-1:0]  rdata_d, rdata_q;
  logic [NPIN-1:0]    in_level, in_rise, in_fall, status;
  logic [31:0]        bl_word;
  logic               bl_upd, stat_clr;

  assign sel = decode_sel(reg_addr);

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_in),
    .level_o(in_level), .rise_o(in_rise), .fall_o(in_fall)
  );

  gpio_edge_capture #(.W(NPIN)) u_cap (
    .clk(clk), .rst_n(rst_n), .rise_i(in_rise), .fall_i(in_fall),
    .rise_en_i(rise_q), .fall_en_i(fall_q), .clear_i(stat_clr),
    .status_o(status), .irq_o(irq)
  );

  always_comb begin
    out_d  = out_q;
    fall_d = fall_q;
    rise_d = rise_q;
    blen_d = blen_q;
    if (reg_we) begin
      unique case (sel)
        SEL_OUT_LO:  out_d[HALF_W-1:0]      = reg_wdata;
        SEL_OUT_HI:  out_d[NPIN-1:HALF_W]   = reg_wdata;
        SEL_FALL_LO: fall_d[HALF_W-1:0]     = reg_wdata;
        SEL_FALL_HI: fall_d[NPIN-1:HALF_W]  = reg_wdata;
        SEL_RISE_LO: rise_d[HALF_W-1:0]     = reg_wdata;
        SEL_RISE_HI: rise_d[NPIN-1:HALF_W]  = reg_wdata;
        SEL_BLEN:    blen_d                 = reg_wdata[BLEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bl_word = '0;
    bl_word[BL_LSB +: BLEN_W] = out_d[BL_LSB +: BLEN_W];
    bl_word[BLEN_W-1:0]       = blen_d;
  end
  assign bl_upd   = reg_we && (sel == SEL_OUT_HI || sel == SEL_BLEN);
  assign stat_clr = reg_re && (sel == SEL_STAT_HI);

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_OUT_LO:  rdata_d = out_q[HALF_W-1:0];
      SEL_OUT_HI:  rdata_d = out_q[NPIN-1:HALF_W];
      SEL_IN_LO:   rdata_d = in_level[HALF_W-1:0];
      SEL_IN_HI:   rdata_d = in_level[NPIN-1:HALF_W];
      SEL_FALL_LO: rdata_d = fall_q[HALF_W-1:0];
      SEL_FALL_HI: rdata_d = fall_q[NPIN-1:HALF_W];
      SEL_RISE_LO: rdata_d = rise_q[HALF_W-1:0];
      SEL_RISE_HI: rdata_d = rise_q[NPIN-1:HALF_W];
      SEL_STAT_LO: rdata_d = status[HALF_W-1:0];
      SEL_STAT_HI: rdata_d = status[NPIN-1:HALF_W];
      SEL_BLEN:    rdata_d[BLEN_W-1:0] = blen_q;
      default: ;
    endcase
  end

  gpio_bl_level u_bl (
    .clk(clk), .rst_n(rst_n), .upd_i(bl_upd), .word_i(bl_word), .level_o(bl_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      fall_q  <= '0;
      rise_q  <= '0;
      blen_q  <= '0;
      rdata_q <= '0;
    end else begin
      out_q  <= out_d;
      fall_q <= fall_d;
      rise_q <= rise_d;
      blen_q <= blen_d;
      if (reg_re) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign pins_out  = out_q;
  assign ser_sda   = out_q[SDA_BIT];
  assign ser_scl   = out_q[SCL_BIT];

  // R2: a low output write leaves the high half alone
  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_OUT_LO) |=> $stable(pins_out[NPIN-1:HALF_W]));

  // R11: serial lines move only on a high output write
  a_r11_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && sel == SEL_OUT_HI) |=> $stable(ser_sda) && $stable(ser_scl));

  // R9: stored backlight enable never exceeds its field
  a_r9_blen_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && sel == SEL_BLEN) |=> (reg_rdata[HALF_W-1:BLEN_W] == '0));

endmodule

// File: tb/gpio_split_irq_tb.sv
module gpio_split_irq_tb;

  logic        clk, rst_n, reg_we, reg_re;
  logic [11:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [31:0] pins_in, pins_out;
  logic [2:0]  bl_level;
  logic        ser_sda, ser_scl, irq;

  gpio_split_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pins_in(pins_in), .pins_out(pins_out), .bl_level(bl_level),
    .ser_sda(ser_sda), .ser_scl(ser_scl), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend;
  logic [31:0] pin_v;

  localparam logic [11:0] A_OUT = 12'h00C, A_IN = 12'h010, A_FALL = 12'h014,
                          A_RISE = 12'h018, A_STAT = 12'h020, HI = 12'h500,
                          A_BLEN = 12'h508;

  always @(posedge clk) rd_pend <= rst_n && reg_re;

  always @(negedge clk) begin
    if (rd_pend) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL monitor: read data 0x%04h with nothing expected", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: read 0x%04h expected 0x%04h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pins_in = v; pin_v = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] bl_model(input logic [2:0] hi3, input logic [2:0] en);
    logic [31:0] w;
    w = {13'b0, hi3, 13'b0, en};
    case (w)
      32'h7: return 3'd0;
      32'h20000: return 3'd1;
      32'h20001: return 3'd2;
      32'h40000: return 3'd3;
      32'h10006: return 3'd4;
      32'h20005: return 3'd5;
      32'h40003: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    logic [2:0] hs [9];
    logic [2:0] es [9];
    rst_n = 0; reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
    pins_in = '1; pin_v = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 bl_level", {29'b0, bl_level}, 32'd7);
    chk("R1 pins_out", pins_out, 32'h0);
    chk("R1 serial", {30'b0, ser_sda, ser_scl}, 32'h0);
    rd(A_IN, 16'hFFFF, "R1 in lo");
    rd(A_IN + HI, 16'hFFFF, "R1 in hi");
    rd(A_OUT, 16'h0, "R1 out lo");
    rd(A_FALL, 16'h0, "R1 fall lo");
    rd(A_RISE + HI, 16'h0, "R1 rise hi");
    rd(A_STAT, 16'h0, "R1 stat lo");
    rd(A_BLEN, 16'h0, "R1 blen");

    // R2 halfword access
    wr(A_OUT, 16'h1234);
    chk("R2 out lo write", pins_out, 32'h0000_1234);
    wr(A_OUT + HI, 16'h0001);
    chk("R2 out hi write", pins_out, 32'h0001_1234);
    wr(A_OUT, 16'hBEEF);
    chk("R2 out lo keeps hi", pins_out, 32'h0001_BEEF);
    rd(A_OUT + HI, 16'h0001, "R2 out hi read");
    wr(A_RISE, 16'hA5A5);
    wr(A_FALL + HI, 16'h8001);
    rd(A_RISE, 16'hA5A5, "R2 rise lo");
    rd(A_RISE + HI, 16'h0000, "R2 rise hi");
    rd(A_FALL + HI, 16'h8001, "R2 fall hi");
    rd(A_FALL, 16'h0000, "R2 fall lo");

    // R11 serial lines
    wr(A_OUT + HI, 16'h2000);
    chk("R11 sda", {30'b0, ser_sda, ser_scl}, 32'h2);
    wr(A_OUT + HI, 16'h4000);
    chk("R11 scl", {30'b0, ser_sda, ser_scl}, 32'h1);
    wr(A_OUT, 16'h0000);
    chk("R11 lo write no effect", {30'b0, ser_sda, ser_scl}, 32'h1);

    // R3 and R5 (no enable, no effect)
    wr(A_RISE, 16'h0000);
    wr(A_FALL + HI, 16'h0000);
    pins(32'h0000_FF00);
    rd(A_IN, 16'hFF00, "R3 in lo");
    rd(A_IN + HI, 16'h0000, "R3 in hi");
    chk("R5 disabled edges no irq", {31'b0, irq}, 32'h0);
    rd(A_STAT, 16'h0, "R5 disabled edges no status");

    // R4 rising edge
    wr(A_RISE, 16'h0008);
    pins(pin_v | 32'h8);
    chk("R4 irq raised", {31'b0, irq}, 32'h1);
    rd(A_STAT, 16'h0008, "R4 stat lo");
    chk("R8 lo read keeps irq", {31'b0, irq}, 32'h1);
    rd(A_STAT, 16'h0008, "R8 lo read keeps status");
    rd(A_STAT + HI, 16'h0000, "R8 hi read");
    chk("R8 hi read clears irq", {31'b0, irq}, 32'h0);
    rd(A_STAT, 16'h0000, "R8 status cleared");

    // R5 falling edge on pin 20
    wr(A_FALL + HI, 16'h0010);
    pins(pin_v | 32'h0010_0000);
    chk("R5 rise on fall-only pin", {31'b0, irq}, 32'h0);
    pins(pin_v & ~32'h0010_0000);
    chk("R5 irq on fall", {31'b0, irq}, 32'h1);
    rd(A_STAT, 16'h0000, "R5 stat lo");
    rd(A_STAT + HI, 16'h0010, "R5 stat hi");

    // R6 overwrite
    wr(A_FALL, 16'h0008);
    pins(pin_v & ~32'h8);
    rd(A_STAT, 16'h0008, "R6 first edge");
    pins(pin_v | 32'h0010_0000);
    pins(pin_v & ~32'h0010_0000);
    rd(A_STAT, 16'h0000, "R6 old bit gone");
    rd(A_STAT + HI, 16'h0010, "R6 new bit");

    // R7 simultaneous edges
    wr(A_RISE, 16'h0030);
    pins(pin_v | 32'h30);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    rd(A_STAT, 16'h0010, "R7 lowest pin");
    rd(A_STAT + HI, 16'h0000, "R7 clear");

    // R9 backlight enable field
    wr(A_BLEN, 16'hFFFF);
    rd(A_BLEN, 16'h0007, "R9 masked readback");

    // R10 backlight table
    hs = '{3'd0, 3'd2, 3'd2, 3'd4, 3'd1, 3'd2, 3'd4, 3'd3, 3'd5};
    es = '{3'd7, 3'd0, 3'd1, 3'd0, 3'd6, 3'd5, 3'd3, 3'd4, 3'd5};
    for (int i = 0; i < 9; i++) begin
      wr(A_BLEN, {13'b0, es[i]});
      wr(A_OUT + HI, {13'b0, hs[i]});
      chk($sformatf("R10 case %0d", i), {29'b0, bl_level}, {29'b0, bl_model(hs[i], es[i])});
    end
    wr(A_BLEN, 16'h0004);
    chk("R10 enable write recomputes", {29'b0, bl_level}, {29'b0, bl_model(3'd5, 3'd4)});

    // R12 ignored writes and unmapped reads
    wr(A_IN, 16'h0000);
    rd(A_IN, pin_v[15:0], "R12 in write ignored");
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, 16'h0000, "R12 status write ignored");
    wr(12'h100, 16'hFFFF);
    rd(A_OUT, 16'h0000, "R12 unmapped write ignored");
    rd(12'h100, 16'h0000, "R12 unmapped read");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 32'h0);
    summary();
  end

endmodule